// File: doc/BRIEF.md
# Dual-Mode Serial Slave Port (SPI / UART)

This block is the host-facing serial front end of a larger device. One set of pins carries either a 4-wire SPI slave or a full-duplex 8N1 UART. A static mode input chooses the active interface. Inside the device, received bytes leave on a one-cycle valid strobe. Bytes to send enter a one-byte holding buffer through a valid/ready handshake.

Everything runs on the master clock. Chip select, serial clock and the data/receive pin are double-flop synchronized, and serial clock edges are found in the master clock domain. The UART bit rate comes from a 16-bit rate word. That word drives a phase accumulator, which gives 16 ticks per bit. A low chip select enables either interface, so several slaves can share the serial lines. While chip select is high the output pin is released.

Top module: `serial_slave_port`

## Requirements
- R1: `mode_sel` low selects SPI and high selects UART. Only the selected engine drives `so`/`so_oe` and takes bytes from the transmit buffer.
- R2: In SPI mode with `cs_n` low, `sdi_rx` is sampled on each rising `sclk` edge, most significant bit first. After the eighth rising edge the byte appears on `rx_data` with a `rx_valid` pulse.
- R3: SPI output is shifted MSB first, and `so` advances after each falling `sclk` edge. A new byte is taken from the transmit buffer when `cs_n` falls and after every eighth rising edge. If the buffer is empty at that moment, 0x00 is sent.
- R4: While `cs_n` is high in SPI mode, `so_oe` is low and the bit count and shift registers are cleared, so a partial byte is discarded.
- R5: In UART mode, frames on `sdi_rx` are received as 1 low start bit, 8 data bits LSB first and 1 stop bit, each bit sampled at its centre. The byte is reported on `rx_data` with a `rx_valid` pulse.
- R6: A UART frame whose stop bit samples low is reported with `rx_err` high in the same cycle as `rx_valid`. After such a frame, a new start bit is accepted only once the line has been seen high.
- R7: The UART transmitter sends a buffered byte as start (0), 8 data bits LSB first and stop (1), and holds `so` high between frames.
- R8: The UART bit period is 2^19 / BR master-clock cycles, where BR is the 16-bit rate word written through `baud_we`/`baud_wdata`. The rate word resets to 0x004C.
- R9: In UART mode with `cs_n` high, `so_oe` is low, received frames produce no `rx_valid`, and the buffered transmit byte is held until `cs_n` goes low.
- R10: The transmit buffer holds one byte. `tx_ready` is low while it is full, and a full buffer keeps its byte unchanged until an engine takes it.
- R11: `rx_valid` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 1 | 0 = SPI, 1 = UART (pad has a pull-up) |
| cs_n | input | 1 | Active-low chip select for both modes |
| sclk | input | 1 | SPI serial clock (at most clk/4) |
| sdi_rx | input | 1 | SPI data in / UART receive line |
| so | output | 1 | SPI data out / UART transmit line |
| so_oe | output | 1 | Output enable for the `so` pad buffer |
| baud_we | input | 1 | Write strobe for the UART rate word |
| baud_wdata | input | 16 | New UART rate word |
| tx_valid | input | 1 | Byte offered to the transmit buffer |
| tx_data | input | 8 | Byte to transmit |
| tx_ready | output | 1 | Transmit buffer empty |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_data | output | 8 | Received byte |
| rx_err | output | 1 | Framing error flag, valid with `rx_valid` |

## Verification
A wrong SPI bit count shows up as a byte rotated or shifted on `rx_data`, or as a next outgoing byte offset on `so`, within the same 8-edge transfer. A stale shift state across a chip-select release corrupts the first byte after reselection. A wrong receiver or transmitter state in UART mode shows up as a missing, doubled or misframed byte within one frame time (10 bit periods). A wrong rate word shows up as a bit period that is off by the ratio of the rates, which the bench measures directly at the reset default.

// File: rtl/ssp_pkg.sv
`timescale 1ns/1ps
package ssp_pkg;
   localparam int RATE_FRAC_W = 19;   // rate word is scaled by 2^19 of the master clock
   typedef enum logic [1:0] {
      FR_IDLE,
      FR_START,
      FR_DATA,
      FR_STOP
   } frame_st_e;
endpackage

// File: rtl/ssp_sync.sv
`timescale 1ns/1ps
module ssp_sync #(
   parameter int          W       = 1,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      logic [1:0] ff;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ff <= {2{RST_VAL[i]}};
         else        ff <= {ff[0], d[i]};
      end
      assign q[i] = ff[1];
   end
endmodule

// File: rtl/ssp_baud_gen.sv
`timescale 1ns/1ps
module ssp_baud_gen #(
   parameter int              BR_W     = 16,
   parameter int              OVS_LOG2 = 4,
   parameter logic [BR_W-1:0] BR_RESET = 16'h004C
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [BR_W-1:0] wdata,
   output logic            tick
);
   localparam int ACC_W = ssp_pkg::RATE_FRAC_W - OVS_LOG2;
   localparam int SUM_W = ((BR_W > ACC_W) ? BR_W : ACC_W) + 1;
   localparam int HALF  = 1 << (ACC_W - 1);

   if (OVS_LOG2 < 2 || OVS_LOG2 > 4) begin : g_bad_ovs
      $error("ssp_baud_gen: OVS_LOG2 must be 2..4");
   end

   logic [BR_W-1:0]  br;
   logic [ACC_W-1:0] acc;
   logic [SUM_W-1:0] sum;

   assign sum  = SUM_W'(acc) + SUM_W'(br);
   assign tick = |sum[SUM_W-1:ACC_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         br  <= BR_RESET;
         acc <= '0;
      end else begin
         acc <= sum[ACC_W-1:0];
         if (we) br <= wdata;
      end
   end

   // R8: with an increment under half the wrap, two overflows cannot be adjacent
   assert_tick_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !we && (int'(br) < HALF)) |=> !tick);
endmodule

// File: rtl/ssp_spi_slave.sv
`timescale 1ns/1ps
module ssp_spi_slave #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         cs_s,
   input  logic         sclk_s,
   input  logic         sdi_s,
   input  logic         pend_valid,
   input  logic [W-1:0] pend_data,
   output logic         pend_take,
   output logic         rx_valid,
   output logic [W-1:0] rx_data,
   output logic         sdo,
   output logic         sdo_oe
);
   localparam int CW = $clog2(W);

   logic          active, act_q, sclk_q, rise, fall, load;
   logic [CW-1:0] bitcnt;
   logic [W-1:0]  rsh, tsh;

   assign active    = en & ~cs_s;
   assign rise      = active & sclk_s & ~sclk_q;
   assign fall      = active & ~sclk_s & sclk_q;
   assign load      = (active & ~act_q) | (rise & (bitcnt == CW'(W-1)));
   assign pend_take = load & pend_valid;
   assign sdo       = tsh[W-1];
   assign sdo_oe    = active;
   assign rx_data   = rsh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q    <= 1'b0;
         sclk_q   <= 1'b0;
         bitcnt   <= '0;
         rsh      <= '0;
         tsh      <= '0;
         rx_valid <= 1'b0;
      end else begin
         act_q    <= active;
         sclk_q   <= sclk_s;
         rx_valid <= 1'b0;
         if (!active) begin
            bitcnt <= '0;
            rsh    <= '0;
            tsh    <= '0;
         end else begin
            if (rise) begin
               rsh <= {rsh[W-2:0], sdi_s};
               if (bitcnt == CW'(W-1)) begin
                  bitcnt   <= '0;
                  rx_valid <= 1'b1;
               end else begin
                  bitcnt <= bitcnt + 1'b1;
               end
            end
            if (load)                      tsh <= pend_valid ? pend_data : '0;
            else if (fall && bitcnt != '0) tsh <= {tsh[W-2:0], 1'b0};
         end
      end
   end

   // R3: a byte taken from the buffer presents its MSB on the next cycle
   assert_msb_after_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pend_take |=> (!active || sdo == $past(pend_data[W-1])));
   // R4: releasing chip select drops any partial byte
   assert_partial_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $rose(cs_s)) |=> (bitcnt == '0 && tsh == '0));
endmodule

// File: rtl/ssp_uart.sv
`timescale 1ns/1ps
module ssp_uart #(
   parameter int W        = 8,
   parameter int OVS_LOG2 = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         cs_s,
   input  logic         rx_s,
   input  logic         tick,
   input  logic         pend_valid,
   input  logic [W-1:0] pend_data,
   output logic         pend_take,
   output logic         rx_valid,
   output logic [W-1:0] rx_data,
   output logic         rx_err,
   output logic         tx_o,
   output logic         tx_oe
);
   import ssp_pkg::*;
   localparam int OVS = 1 << OVS_LOG2;
   localparam int CW  = $clog2(W);
   localparam logic [OVS_LOG2-1:0] MID  = OVS_LOG2'(OVS/2 - 1);
   localparam logic [OVS_LOG2-1:0] LAST = OVS_LOG2'(OVS - 1);

   logic active;
   assign active = en & ~cs_s;
   assign tx_oe  = active;

   // receiver
   frame_st_e           r_st;
   logic [OVS_LOG2-1:0] r_cnt;
   logic [CW-1:0]       r_bit;
   logic [W-1:0]        r_sh;
   logic                armed;

   assign rx_data = r_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         r_st <= FR_IDLE; r_cnt <= '0; r_bit <= '0; r_sh <= '0;
         armed <= 1'b0; rx_valid <= 1'b0; rx_err <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         rx_err   <= 1'b0;
         if (!active) begin
            r_st  <= FR_IDLE;
            armed <= 1'b0;
         end else if (tick) begin
            case (r_st)
               FR_IDLE: begin
                  if (rx_s) armed <= 1'b1;
                  else if (armed) begin
                     r_st <= FR_START; r_cnt <= '0; armed <= 1'b0;
                  end
               end
               FR_START: begin
                  if (r_cnt == MID) begin
                     r_cnt <= '0; r_bit <= '0;
                     r_st  <= rx_s ? FR_IDLE : FR_DATA;
                  end else r_cnt <= r_cnt + 1'b1;
               end
               FR_DATA: begin
                  if (r_cnt == LAST) begin
                     r_cnt <= '0;
                     r_sh  <= {rx_s, r_sh[W-1:1]};
                     if (r_bit == CW'(W-1)) r_st <= FR_STOP;
                     else                   r_bit <= r_bit + 1'b1;
                  end else r_cnt <= r_cnt + 1'b1;
               end
               default: begin
                  if (r_cnt == LAST) begin
                     r_cnt <= '0; r_st <= FR_IDLE;
                     rx_valid <= 1'b1; rx_err <= ~rx_s;
                  end else r_cnt <= r_cnt + 1'b1;
               end
            endcase
         end
      end
   end

   // transmitter
   frame_st_e           t_st;
   logic [OVS_LOG2-1:0] t_cnt;
   logic [CW-1:0]       t_bit;
   logic [W-1:0]        t_sh;

   assign pend_take = active & (t_st == FR_IDLE) & pend_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         t_st <= FR_IDLE; t_cnt <= '0; t_bit <= '0; t_sh <= '0; tx_o <= 1'b1;
      end else if (!active) begin
         t_st <= FR_IDLE; tx_o <= 1'b1;
      end else begin
         case (t_st)
            FR_IDLE: if (pend_take) begin
               t_sh <= pend_data; t_st <= FR_START; t_cnt <= '0; tx_o <= 1'b0;
            end
            FR_START: if (tick) begin
               if (t_cnt == LAST) begin
                  t_cnt <= '0; t_bit <= '0; t_st <= FR_DATA; tx_o <= t_sh[0];
               end else t_cnt <= t_cnt + 1'b1;
            end
            FR_DATA: if (tick) begin
               if (t_cnt == LAST) begin
                  t_cnt <= '0;
                  if (t_bit == CW'(W-1)) begin
                     t_st <= FR_STOP; tx_o <= 1'b1;
                  end else begin
                     t_bit <= t_bit + 1'b1;
                     t_sh  <= {1'b1, t_sh[W-1:1]};
                     tx_o  <= t_sh[1];
                  end
               end else t_cnt <= t_cnt + 1'b1;
            end
            default: if (tick) begin
               if (t_cnt == LAST) begin
                  t_cnt <= '0; t_st <= FR_IDLE;
               end else t_cnt <= t_cnt + 1'b1;
            end
         endcase
      end
   end

   // R7: accepting a byte puts the start bit on the line in the next cycle
   assert_start_after_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pend_take |=> (!active || !tx_o));
   // R6: an error flag only comes with a received byte
   assert_err_with_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_err |-> rx_valid);
endmodule

// File: rtl/serial_slave_port.sv
`timescale 1ns/1ps
module serial_slave_port #(
   parameter int              W        = 8,
   parameter int              BR_W     = 16,
   parameter logic [BR_W-1:0] BR_RESET = 16'h004C,
   parameter int              OVS_LOG2 = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            mode_sel,
   input  logic            cs_n,
   input  logic            sclk,
   input  logic            sdi_rx,
   output logic            so,
   output logic            so_oe,
   input  logic            baud_we,
   input  logic [BR_W-1:0] baud_wdata,
   input  logic            tx_valid,
   input  logic [W-1:0]    tx_data,
   output logic            tx_ready,
   output logic            rx_valid,
   output logic [W-1:0]    rx_data,
   output logic            rx_err
);
   if (W < 2) begin : g_bad_w
      $error("serial_slave_port: W must be at least 2");
   end

   logic mode_s, cs_s, sclk_s, din_s;
   ssp_sync #(.W(4), .RST_VAL(4'b1101)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({mode_sel, cs_n, sclk, sdi_rx}),
      .q({mode_s, cs_s, sclk_s, din_s})
   );

   logic tick;
   ssp_baud_gen #(.BR_W(BR_W), .OVS_LOG2(OVS_LOG2), .BR_RESET(BR_RESET)) u_baud (
      .clk(clk), .rst_n(rst_n), .we(baud_we), .wdata(baud_wdata), .tick(tick)
   );

   // one-byte transmit holding buffer shared by both engines
   logic         pend_valid, pend_take, s_take, u_take;
   logic [W-1:0] pend_data;
   assign tx_ready  = ~pend_valid;
   assign pend_take = s_take | u_take;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_valid <= 1'b0;
         pend_data  <= '0;
      end else if (tx_valid && !pend_valid) begin
         pend_valid <= 1'b1;
         pend_data  <= tx_data;
      end else if (pend_take) begin
         pend_valid <= 1'b0;
      end
   end

   logic         s_rv, s_sdo, s_oe;
   logic [W-1:0] s_rd;
   ssp_spi_slave #(.W(W)) u_spi (
      .clk(clk), .rst_n(rst_n), .en(~mode_s), .cs_s(cs_s), .sclk_s(sclk_s),
      .sdi_s(din_s), .pend_valid(pend_valid), .pend_data(pend_data),
      .pend_take(s_take), .rx_valid(s_rv), .rx_data(s_rd), .sdo(s_sdo), .sdo_oe(s_oe)
   );

   logic         u_rv, u_err, u_tx, u_oe;
   logic [W-1:0] u_rd;
   ssp_uart #(.W(W), .OVS_LOG2(OVS_LOG2)) u_uart (
      .clk(clk), .rst_n(rst_n), .en(mode_s), .cs_s(cs_s), .rx_s(din_s), .tick(tick),
      .pend_valid(pend_valid), .pend_data(pend_data), .pend_take(u_take),
      .rx_valid(u_rv), .rx_data(u_rd), .rx_err(u_err), .tx_o(u_tx), .tx_oe(u_oe)
   );

   assign rx_valid = mode_s ? u_rv  : s_rv;
   assign rx_data  = mode_s ? u_rd  : s_rd;
   assign rx_err   = mode_s & u_err;
   assign so       = mode_s ? u_tx  : s_sdo;
   assign so_oe    = mode_s ? u_oe  : s_oe;

   // R1: at most one engine drains the buffer
   assert_single_taker_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({s_take, u_take}));
   // R4, R9: deselected port never drives the pin
   assert_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cs_s |-> !so_oe);
   // R10: a full buffer keeps its byte until taken
   assert_hold_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_valid && !pend_take) |=> (pend_valid && $stable(pend_data)));
   // R11: receive strobe lasts one cycle
   assert_valid_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);
endmodule

// File: tb/serial_slave_port_tb.sv
`timescale 1ns/1ps
module serial_slave_port_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_sel = 1'b0, cs_n = 1'b1, sclk = 1'b0, sdi_rx = 1'b1;
   logic        baud_we = 1'b0;
   logic [15:0] baud_wdata = '0;
   logic        tx_valid = 1'b0;
   logic [7:0]  tx_data = '0;
   logic        so, so_oe, tx_ready, rx_valid, rx_err;
   logic [7:0]  rx_data;

   always #4 clk = ~clk;   // 125 MHz

   serial_slave_port u_dut (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cs_n(cs_n), .sclk(sclk),
      .sdi_rx(sdi_rx), .so(so), .so_oe(so_oe), .baud_we(baud_we),
      .baud_wdata(baud_wdata), .tx_valid(tx_valid), .tx_data(tx_data),
      .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data), .rx_err(rx_err)
   );

   int n_chk = 0, n_bad = 0, rx_seen = 0;
   logic [8:0] exp_q[$];
   bit done = 1'b0;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor: every received byte is compared against the scoreboard queue
   always @(negedge clk) begin
      if (rst_n && rx_valid) begin
         logic [8:0] e;
         rx_seen++;
         if (exp_q.size() == 0) check(1'b0, "R2/R5/R9 unexpected byte", {rx_err, rx_data}, 0);
         else begin
            e = exp_q.pop_front();
            check({rx_err, rx_data} == e, "R2/R5/R6 received byte", {rx_err, rx_data}, e);
         end
      end
   end

   task automatic tx_put(input logic [7:0] b);
      @(negedge clk);
      while (!tx_ready) @(negedge clk);
      tx_valid = 1'b1; tx_data = b;
      @(negedge clk);
      tx_valid = 1'b0;
   endtask

   task automatic spi_byte(input logic [7:0] mosi, input logic [7:0] exp_miso);
      logic [7:0] got;
      exp_q.push_back({1'b0, mosi});
      for (int i = 7; i >= 0; i--) begin
         sdi_rx = mosi[i];
         repeat (8) @(negedge clk);
         sclk = 1'b1; got[i] = so;
         repeat (8) @(negedge clk);
         sclk = 1'b0;
      end
      repeat (8) @(negedge clk);
      check(got == exp_miso, "R3 SPI output byte", got, exp_miso);
   endtask

   task automatic uart_send(input logic [7:0] b, input logic stop, input bit push);
      if (push) exp_q.push_back({~stop, b});
      sdi_rx = 1'b0; repeat (128) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         sdi_rx = b[i]; repeat (128) @(negedge clk);
      end
      sdi_rx = stop; repeat (128) @(negedge clk);
      sdi_rx = 1'b1;
   endtask

   task automatic uart_cap(input logic [7:0] exp);
      logic [7:0] got;
      @(negedge clk);
      while (so) @(negedge clk);
      repeat (64) @(negedge clk);
      check(so == 1'b0, "R7 start bit", so, 0);
      for (int i = 0; i < 8; i++) begin
         repeat (128) @(negedge clk);
         got[i] = so;
      end
      repeat (128) @(negedge clk);
      check(so == 1'b1, "R7 stop bit", so, 1);
      check(got == exp, "R7 UART sent byte", got, exp);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         check(1'b0, "watchdog expired", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int n0, len;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check(so_oe == 1'b0 && tx_ready == 1'b1 && rx_valid == 1'b0,
            "reset state", {so_oe, tx_ready, rx_valid}, 3'b010);

      // ---------------- SPI mode ----------------
      tx_put(8'hA5);
      repeat (4) @(negedge clk);
      check(tx_ready == 1'b0, "R10 buffer full", tx_ready, 0);
      cs_n = 1'b0;
      repeat (10) @(negedge clk);
      check(so_oe == 1'b1 && so == 1'b1, "R1 SPI drives MSB of 0xA5", {so_oe, so}, 2'b11);
      tx_put(8'h5A);
      spi_byte(8'h3C, 8'hA5);
      spi_byte(8'hC3, 8'h5A);
      spi_byte(8'h7E, 8'h00);          // R3 empty buffer sends zero
      cs_n = 1'b1;
      repeat (10) @(negedge clk);
      check(so_oe == 1'b0, "R4 SDO released", so_oe, 0);
      // R4 partial byte discarded
      cs_n = 1'b0; sdi_rx = 1'b1;
      repeat (10) @(negedge clk);
      for (int i = 0; i < 3; i++) begin
         sclk = 1'b1; repeat (8) @(negedge clk);
         sclk = 1'b0; repeat (8) @(negedge clk);
      end
      cs_n = 1'b1; repeat (10) @(negedge clk);
      cs_n = 1'b0; repeat (10) @(negedge clk);
      spi_byte(8'h81, 8'h00);
      cs_n = 1'b1; sdi_rx = 1'b1;
      repeat (10) @(negedge clk);

      // ---------------- UART mode ----------------
      mode_sel = 1'b1; cs_n = 1'b0;
      repeat (20) @(negedge clk);
      check(so == 1'b1 && so_oe == 1'b1, "R1 UART idle high", {so, so_oe}, 2'b11);
      // R8 default rate word 0x004C: start bit about 6898 cycles
      tx_put(8'h55);
      while (so) @(negedge clk);
      len = 0;
      while (!so) begin @(negedge clk); len++; end
      check(len >= 6400 && len <= 6950, "R8 default bit period", len, 6898);
      repeat (63000) @(negedge clk);
      check(tx_ready == 1'b1 && so == 1'b1, "R7 idle after frame", {tx_ready, so}, 2'b11);
      @(negedge clk); baud_we = 1'b1; baud_wdata = 16'd4096;
      @(negedge clk); baud_we = 1'b0;
      repeat (300) @(negedge clk);

      // R5 full duplex
      fork
         uart_send(8'hA7, 1'b1, 1'b1);
         begin tx_put(8'hC4); uart_cap(8'hC4); end
      join
      uart_send(8'h00, 1'b1, 1'b1);
      uart_send(8'hFF, 1'b1, 1'b1);
      // R6 framing error, then recovery
      uart_send(8'h3E, 1'b0, 1'b1);
      repeat (256) @(negedge clk);
      uart_send(8'h12, 1'b1, 1'b1);
      repeat (200) @(negedge clk);
      // R7/R10 back-to-back transmit
      fork
         begin tx_put(8'h11); tx_put(8'h22); end
         begin uart_cap(8'h11); uart_cap(8'h22); end
      join
      repeat (200) @(negedge clk);

      // R9 chip select gating
      cs_n = 1'b1;
      repeat (10) @(negedge clk);
      check(so_oe == 1'b0, "R9 TX released", so_oe, 0);
      n0 = rx_seen;
      uart_send(8'h99, 1'b1, 1'b0);
      repeat (300) @(negedge clk);
      check(rx_seen == n0, "R9 RX ignored while deselected", rx_seen, n0);
      tx_put(8'h6D);
      repeat (300) @(negedge clk);
      check(tx_ready == 1'b0, "R9 byte held while deselected", tx_ready, 0);
      fork
         begin repeat (2) @(negedge clk); cs_n = 1'b0; end
         uart_cap(8'h6D);
      join
      repeat (300) @(negedge clk);

      check(exp_q.size() == 0, "R2/R5 all expected bytes seen", exp_q.size(), 0);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule